// File: doc/BRIEF.md
# Width-Adaptive Bus Access Qualifier

This block produces the per-transaction qualifier lines of a multiplexed external bus. The bus can reach memory regions that are 8, 16 or 32 bits wide. A request is presented together with an address-phase strobe. The request carries:

- the two low address bits
- an access size code
- the width code of the target region
- a data/instruction flag
- a write flag

The block then registers four active-low byte-enable lines, a two-bit width code, a data/code line and a write/read line. All of them stay stable through every data cycle that follows.

The meaning of the byte-enable pins depends on the region width. For a 32-bit region they are four lane enables. For a 16-bit region they become a high-byte enable, an unused pin, address bit 1 and a low-byte enable. For an 8-bit region they become two unused pins and address bits 1 and 0.

A halt input forces the reserved width code 11. While the bus is granted away, an output-enable flag drops, so that the width code can be floated at the pad. Every request is assumed to be aligned already and to fit within the region width.

Top module: `bus_qualifier`

## Requirements
- R1: A synchronous reset sets `be_n` to 4'b1111, `dc` and `wr` to 0, and `width_code` to 2'b00. With `hold_ack` low, `width_oe` reads 1.
- R2: Region code 2'b10 selects a 32-bit region. Bit k of `be_n` is driven low when byte lane k (bits 8k+7:8k) falls inside the access. For size code 00 (1 byte) that is lane `addr_lo`. For size code 01 (2 bytes) it is lanes `addr_lo` and `addr_lo`+1. For size code 10 (4 bytes) it is all four lanes.
- R3: Region code 2'b01 selects a 16-bit region. Then `be_n[3]` is the active-low high-byte enable (0 when the access touches byte offset 1 of the halfword), `be_n[2]` is 1, `be_n[1]` equals `addr_lo[1]`, and `be_n[0]` is the active-low low-byte enable (0 when the access touches offset 0).
- R4: Region code 2'b00 selects an 8-bit region. Then `be_n[3:2]` is 2'b11, `be_n[1]` equals `addr_lo[1]` and `be_n[0]` equals `addr_lo[0]`.
- R5: After an accepted address phase, `width_code` equals the region code: 00 for 8-bit, 01 for 16-bit, 10 for 32-bit.
- R6: When `halt` is sampled high at a clock edge, `width_code` reads 2'b11 after that edge. This overrides the stored region code.
- R7: On an accepted address phase, `wr` captures the write flag (1 = write, 0 = read) and `dc` captures the data flag (1 = data, 0 = instruction). Both are visible after that edge.
- R8: While `ta_start` is low, `be_n`, `dc`, `wr` and the stored width code keep their values through any number of data cycles, whatever the other request inputs do.
- R9: While `hold_ack` is high, `width_oe` is 0 in the same cycle, and an address-phase strobe is ignored: all registered outputs are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ta_start | input | 1 | Address-phase strobe; loads the qualifiers |
| addr_lo | input | 2 | Low address bits of the request |
| size_code | input | 2 | 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes |
| region_width | input | 2 | 00 = 8-bit, 01 = 16-bit, 10 = 32-bit region |
| data_access | input | 1 | 1 for data, 0 for instruction fetch |
| write_access | input | 1 | 1 for write, 0 for read |
| halt | input | 1 | Processor halted indication |
| hold_ack | input | 1 | Bus granted away in response to a hold request |
| be_n | output | 4 | Byte enables / address bits, width dependent |
| width_code | output | 2 | Region width code, or 11 when halted |
| width_oe | output | 1 | Drive enable for the width code pins |
| dc | output | 1 | Data/code qualifier |
| wr | output | 1 | Write/read qualifier |

## Verification
The block has no parameters, so the bench uses the one fixed configuration. That configuration is small enough to sweep every aligned, width-fitting combination of region, size and low address with all four flag pairs, and to compare each result against lane masks built arithmetically. Each access is followed by idle cycles with scrambled request inputs to confirm the hold-through-data-phase rule. Separate passes cover halt overriding each stored width, and a strobe arriving while the bus is granted away.

// File: rtl/bus_qualifier.sv
module bus_qualifier (
  input  logic       clk,
  input  logic       rst,
  input  logic       ta_start,
  input  logic [1:0] addr_lo,
  input  logic [1:0] size_code,
  input  logic [1:0] region_width,
  input  logic       data_access,
  input  logic       write_access,
  input  logic       halt,
  input  logic       hold_ack,
  output logic [3:0] be_n,
  output logic [1:0] width_code,
  output logic       width_oe,
  output logic       dc,
  output logic       wr
);

  logic [3:0] be_q, be_next;
  logic [1:0] width_q, width_next;
  logic       halt_q, dc_q, wr_q;
  logic       load;
  logic       lo_n, hi_n;

  assign load = ta_start & ~hold_ack;

  always_comb begin
    if (size_code == 2'b00) begin
      lo_n = addr_lo[0];
      hi_n = ~addr_lo[0];
    end else begin
      lo_n = 1'b0;
      hi_n = 1'b0;
    end
  end

  always_comb begin
    case (region_width)
      2'b00: be_next = {2'b11, addr_lo[1], addr_lo[0]};
      2'b01: be_next = {hi_n, 1'b1, addr_lo[1], lo_n};
      default: begin
        case (size_code)
          2'b00: be_next = ~(4'b0001 << addr_lo);
          2'b01: be_next = addr_lo[1] ? 4'b0011 : 4'b1100;
          default: be_next = 4'b0000;
        endcase
      end
    endcase
  end

  // A reserved region code is treated as a full-width region.
  assign width_next = (region_width == 2'b11) ? 2'b10 : region_width;

  always_ff @(posedge clk) begin
    if (rst) begin
      be_q    <= 4'b1111;
      width_q <= 2'b00;
      dc_q    <= 1'b0;
      wr_q    <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      halt_q <= halt;
      if (load) begin
        be_q    <= be_next;
        width_q <= width_next;
        dc_q    <= data_access;
        wr_q    <= write_access;
      end
    end
  end

  assign be_n       = be_q;
  assign dc         = dc_q;
  assign wr         = wr_q;
  assign width_code = halt_q ? 2'b11 : width_q;
  assign width_oe   = ~hold_ack;

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !ta_start |=> ($stable(be_n) && $stable(dc) && $stable(wr))); // R8
  AST_GRANT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    hold_ack |=> ($stable(be_n) && $stable(wr))); // R9
  AST_FLAG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (ta_start && !hold_ack) |=> (wr == $past(write_access) && dc == $past(data_access))); // R7
  AST_HALT_CODE: assert property (@(posedge clk) disable iff (rst)
    halt |=> width_code == 2'b11); // R6
  AST_NARROW_UNUSED: assert property (@(posedge clk) disable iff (rst)
    width_code == 2'b00 |-> be_n[3:2] == 2'b11); // R4
  AST_HALF_UNUSED: assert property (@(posedge clk) disable iff (rst)
    width_code == 2'b01 |-> be_n[2]); // R3
  AST_WIDE_LANE: assert property (@(posedge clk) disable iff (rst)
    (width_code == 2'b10 && !$stable(be_n)) |-> be_n != 4'b1111); // R2

endmodule

// File: tb/bus_qualifier_test.sv
module bus_qualifier_test;
  logic clk = 0, rst = 1, ta_start = 0, data_access = 0, write_access = 0, halt = 0, hold_ack = 0;
  logic [1:0] addr_lo = 0, size_code = 0, region_width = 0;
  logic [3:0] be_n;
  logic [1:0] width_code;
  logic width_oe, dc, wr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  bus_qualifier uut (.clk(clk), .rst(rst), .ta_start(ta_start), .addr_lo(addr_lo),
    .size_code(size_code), .region_width(region_width), .data_access(data_access),
    .write_access(write_access), .halt(halt), .hold_ack(hold_ack), .be_n(be_n),
    .width_code(width_code), .width_oe(width_oe), .dc(dc), .wr(wr));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(int r, int s, int a);
    int n = 1 << s;
    logic [3:0] mask = 0;
    logic lo, hi;
    for (int i = 0; i < n; i++) mask[(a + i) % 4] = 1'b1;
    if (r == 2) return ~mask;
    if (r == 1) begin
      lo = ((a % 2) == 0);
      hi = ((a % 2) + n - 1) >= 1;
      return {~hi, 1'b1, 1'(a / 2), ~lo};
    end
    return {2'b11, 1'(a / 2), 1'(a % 2)};
  endfunction

  task automatic access(int r, int s, int a, logic d, logic w);
    @(negedge clk);
    region_width = 2'(r); size_code = 2'(s); addr_lo = 2'(a);
    data_access = d; write_access = w; ta_start = 1;
    @(negedge clk);
    ta_start = 0;
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [3:0] eb;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 be_n", 8'(be_n), 8'hF);
    chk("R1 dc/wr", {6'b0, dc, wr}, 8'h0);
    chk("R1 width", 8'(width_code), 8'h0);
    chk("R1 oe", 8'(width_oe), 8'h1);

    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 3; s++)
        for (int a = 0; a < 4; a++) begin
          if ((1 << s) > (1 << r) || (a % (1 << s)) != 0) continue;
          for (int f = 0; f < 4; f++) begin
            access(r, s, a, f[1], f[0]);
            eb = exp_be(r, s, a);
            chk(r == 2 ? "R2 be_n" : (r == 1 ? "R3 be_n" : "R4 be_n"), 8'(be_n), 8'(eb));
            chk("R5 width", 8'(width_code), 8'(r));
            chk("R7 dc/wr", {6'b0, dc, wr}, {6'b0, f[1], f[0]});
            for (int k = 0; k < 3; k++) begin
              region_width = 2'((r + 1 + k) % 3); size_code = 2'(k);
              addr_lo = 2'(a + 1 + k); data_access = ~f[1]; write_access = ~f[0];
              @(negedge clk);
              chk("R8 hold", {be_n, width_code, dc, wr}, {eb, 2'(r), f[1], f[0]});
            end
          end
        end

    for (int r = 0; r < 3; r++) begin
      access(r, 0, 0, 1, 0);
      halt = 1;
      @(negedge clk);
      chk("R6 halt code", 8'(width_code), 8'h3);
      halt = 0;
      @(negedge clk);
      chk("R6 release", 8'(width_code), 8'(r));
    end

    access(2, 2, 0, 1, 1);
    hold_ack = 1;
    #1;
    chk("R9 oe low", 8'(width_oe), 8'h0);
    @(negedge clk);
    region_width = 0; addr_lo = 3; size_code = 0; data_access = 0; write_access = 0; ta_start = 1;
    @(negedge clk);
    ta_start = 0;
    chk("R9 ignored be", 8'(be_n), 8'h0);
    chk("R9 ignored flags", {4'b0, width_code, dc, wr}, 8'b0000_1011);
    hold_ack = 0;
    #1;
    chk("R9 oe back", 8'(width_oe), 8'h1);

    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 rereset", {be_n, width_code, dc, wr}, 8'hF0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule